// File: doc/BRIEF.md
# Cascadable Arithmetic/Logic Unit with Group Carry Lookahead

This block is a purely combinational arithmetic/logic unit, 8 bits wide in its default form, made of two identical 4-bit slices. Every slice accepts two operand nibbles, a mode bit, a 4-bit operation code and a carry input. It returns a result nibble, a carry output, an operand-equality flag, and a group propagate/generate pair.

The slices are chained by carry: the low slice's carry output drives the high slice's carry input. In parallel, a lookahead combiner forms the word carry-out from the group signals of the slices and the word carry input. Both carry outputs are brought out so the two paths can be compared. In logic mode the carry path takes no part in the result.

Arithmetic codes produce X + Y + cin, where X and Y are selected from A, B and constants. The word equality flag is the AND of the equality flags of the slices.

Top module: `alu_cascade8`

## Requirements
- R1: `mode_i` = 0 selects arithmetic operation and `mode_i` = 1 selects bitwise logic operation; the same operands and code give different results in the two modes.
- R2: In logic mode, `sel_i` picks the bitwise function per bit: 0 AND, 1 OR, 2 XOR, 3 NOT A, 4 NAND, 5 NOR, 6 XNOR, 7 A, 8 B, 9 all zeros, 10 all ones, 11 A AND NOT B, 12 NOT A AND B, 13 A OR NOT B, 14 NOT A OR B, 15 NOT B.
- R3: In logic mode, `f_o` does not depend on `cin_i`. Both carry outputs are 0, and `grp_prop_o` and `grp_gen_o` are both 0.
- R4: In arithmetic mode, {carry, `f_o`} = X + Y + `cin_i`, where (X, Y) is chosen by `sel_i` as follows. 0 (A, B); 1 (A, NOT B); 2 (A, 0); 3 (A, all ones); 4 (B, NOT A); 5 (A, A); 6 (A, A AND B); 7 (A, A OR B); 8 (A OR B, 0); 9 (A AND B, all ones); 10 (NOT A, 0); 11 (B, 0); 12 (B, all ones); 13 (A, A AND NOT B); 14 (A OR NOT B, 0); 15 (A XOR B, 0).
- R5: Addition (code 0) carries across the slice boundary. 0x0F + 0x01 gives 0x10, and 0xFF + 0x01 gives 0x00 with carry-out 1.
- R6: Subtract (code 1) with `cin_i` = 1 gives A − B. 0x05 − 0x03 gives 0x02 with carry-out 1, meaning no borrow.
- R7: `eq_o` is 1 exactly when A equals B, in either mode. It is formed from each slice's zero test of its A − B result.
- R8: `grp_prop_o` is 1 when every bit of X XOR Y is 1. `grp_gen_o` equals the carry-out of X + Y with a carry input of 0.
- R9: `cout_lookahead_o` equals `cout_ripple_o` for every input.
- R10: A logical OR (logic mode, code 1) of 0x01 and 0x01 returns 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| mode_i | input | 1 | 0 arithmetic, 1 logic |
| sel_i | input | 4 | Operation code within the mode |
| cin_i | input | 1 | Word carry input |
| f_o | output | 8 | Result |
| cout_ripple_o | output | 1 | Carry-out of the top slice in the chain |
| cout_lookahead_o | output | 1 | Carry-out formed from the group signals |
| eq_o | output | 1 | A equals B |
| grp_prop_o | output | 1 | Word group propagate |
| grp_gen_o | output | 1 | Word group generate |

## Verification
The bench builds the block with its default parameters: two slices, each 4 bits wide. With only two slices, every one of the 256 operand pairs of the low slice can be swept across all 32 codes and both carry inputs. A derived high nibble sends each high slice through all of its pairs at the same time, so each slice's carry input is driven from both sides.

The 0x00, 0xFF, 0xAA and 0x55 patterns are then crossed on both operands. These cases push carries fully through the chain or stop them at the slice boundary. They are the cases where the lookahead and ripple carries would differ if either path were wrong.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    localparam int SEL_W = 4;

    typedef enum logic {
        MODE_ARITH = 1'b0,
        MODE_LOGIC = 1'b1
    } alu_mode_e;

    typedef enum logic [SEL_W-1:0] {
        AR_ADD     = 4'd0,
        AR_SUB     = 4'd1,
        AR_INC     = 4'd2,
        AR_DEC     = 4'd3,
        AR_RSUB    = 4'd4,
        AR_DOUBLE  = 4'd5,
        AR_A_PAND  = 4'd6,
        AR_A_POR   = 4'd7,
        AR_OR_C    = 4'd8,
        AR_AND_M1  = 4'd9,
        AR_NEG     = 4'd10,
        AR_PASS_B  = 4'd11,
        AR_B_M1    = 4'd12,
        AR_A_PANDN = 4'd13,
        AR_ORN_C   = 4'd14,
        AR_XOR_C   = 4'd15
    } arith_op_e;

    typedef enum logic [SEL_W-1:0] {
        LG_AND  = 4'd0,
        LG_OR   = 4'd1,
        LG_XOR  = 4'd2,
        LG_NOTA = 4'd3,
        LG_NAND = 4'd4,
        LG_NOR  = 4'd5,
        LG_XNOR = 4'd6,
        LG_A    = 4'd7,
        LG_B    = 4'd8,
        LG_ZERO = 4'd9,
        LG_ONES = 4'd10,
        LG_ANDN = 4'd11,
        LG_NAND_B = 4'd12,
        LG_ORN  = 4'd13,
        LG_NORB = 4'd14,
        LG_NOTB = 4'd15
    } logic_op_e;

    typedef struct packed {
        logic p;
        logic g;
    } grp_t;

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic             mode_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             cin_i,
    output logic [W-1:0]     f_o,
    output logic             cout_o,
    output logic             eq_o,
    output grp_t             grp_o
);

    localparam logic [W-1:0] ONES = '1;

    logic [W-1:0] x, y, pbit, gbit, sum, lres, diff;
    logic [W:0]   c;
    grp_t         grp_a;

    // operand selection for X + Y + cin
    always_comb begin
        x = a_i;
        y = b_i;
        case (arith_op_e'(sel_i))
            AR_ADD:     begin x = a_i;         y = b_i;         end
            AR_SUB:     begin x = a_i;         y = ~b_i;        end
            AR_INC:     begin x = a_i;         y = '0;          end
            AR_DEC:     begin x = a_i;         y = ONES;        end
            AR_RSUB:    begin x = b_i;         y = ~a_i;        end
            AR_DOUBLE:  begin x = a_i;         y = a_i;         end
            AR_A_PAND:  begin x = a_i;         y = a_i & b_i;   end
            AR_A_POR:   begin x = a_i;         y = a_i | b_i;   end
            AR_OR_C:    begin x = a_i | b_i;   y = '0;          end
            AR_AND_M1:  begin x = a_i & b_i;   y = ONES;        end
            AR_NEG:     begin x = ~a_i;        y = '0;          end
            AR_PASS_B:  begin x = b_i;         y = '0;          end
            AR_B_M1:    begin x = b_i;         y = ONES;        end
            AR_A_PANDN: begin x = a_i;         y = a_i & ~b_i;  end
            AR_ORN_C:   begin x = a_i | ~b_i;  y = '0;          end
            AR_XOR_C:   begin x = a_i ^ b_i;   y = '0;          end
            default:    begin x = a_i;         y = b_i;         end
        endcase
    end

    assign pbit = x ^ y;
    assign gbit = x & y;
    assign c[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_chain
        assign c[i+1] = gbit[i] | (pbit[i] & c[i]);
    end

    assign sum = pbit ^ c[W-1:0];

    // group terms: G3 | P3.G2 | P3.P2.G1 | ...  and  P3.P2.P1.P0
    always_comb begin
        grp_a.g = 1'b0;
        grp_a.p = 1'b1;
        for (int i = 0; i < W; i++) begin
            grp_a.g = gbit[i] | (pbit[i] & grp_a.g);
            grp_a.p = grp_a.p & pbit[i];
        end
    end

    always_comb begin
        case (logic_op_e'(sel_i))
            LG_AND:    lres = a_i & b_i;
            LG_OR:     lres = a_i | b_i;
            LG_XOR:    lres = a_i ^ b_i;
            LG_NOTA:   lres = ~a_i;
            LG_NAND:   lres = ~(a_i & b_i);
            LG_NOR:    lres = ~(a_i | b_i);
            LG_XNOR:   lres = ~(a_i ^ b_i);
            LG_A:      lres = a_i;
            LG_B:      lres = b_i;
            LG_ZERO:   lres = '0;
            LG_ONES:   lres = ONES;
            LG_ANDN:   lres = a_i & ~b_i;
            LG_NAND_B: lres = ~a_i & b_i;
            LG_ORN:    lres = a_i | ~b_i;
            LG_NORB:   lres = ~a_i | b_i;
            LG_NOTB:   lres = ~b_i;
            default:   lres = '0;
        endcase
    end

    // equality from a dedicated A - B zero test
    assign diff = a_i + ~b_i + {{(W-1){1'b0}}, 1'b1};
    assign eq_o = (diff == '0);

    always_comb begin
        if (alu_mode_e'(mode_i) == MODE_LOGIC) begin
            f_o    = lres;
            cout_o = 1'b0;
            grp_o  = '0;
        end else begin
            f_o    = sum;
            cout_o = c[W];
            grp_o  = grp_a;
        end
    end

    always_comb begin
        // R4
        arith_sum_chk: assert (mode_i || ({cout_o, f_o} ==
            ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin_i})))
            else $error("slice arithmetic sum mismatch");
        // R3
        logic_carry_zero_chk: assert (!mode_i || (!cout_o && grp_o == '0))
            else $error("logic mode carry or group not zero");
        // R7
        slice_eq_chk: assert (eq_o == (a_i == b_i))
            else $error("slice equality flag mismatch");
    end

endmodule

// File: rtl/alu_carry_lookahead.sv
module alu_carry_lookahead
    import alu_slice_pkg::*;
#(
    parameter int N = 2
) (
    input  grp_t grp_i [N],
    input  logic cin_i,
    output logic cout_o,
    output grp_t grp_o
);

    // Gh | Ph.(Gl | Pl.cin), generalised over N slices
    always_comb begin
        grp_o.g = 1'b0;
        grp_o.p = 1'b1;
        for (int i = 0; i < N; i++) begin
            grp_o.g = grp_i[i].g | (grp_i[i].p & grp_o.g);
            grp_o.p = grp_o.p & grp_i[i].p;
        end
        cout_o = grp_o.g | (grp_o.p & cin_i);
    end

endmodule

// File: rtl/alu_cascade8.sv
module alu_cascade8
    import alu_slice_pkg::*;
#(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 2
) (
    input  logic [SLICE_W*NUM_SLICES-1:0] a_i,
    input  logic [SLICE_W*NUM_SLICES-1:0] b_i,
    input  logic                          mode_i,
    input  logic [3:0]                    sel_i,
    input  logic                          cin_i,
    output logic [SLICE_W*NUM_SLICES-1:0] f_o,
    output logic                          cout_ripple_o,
    output logic                          cout_lookahead_o,
    output logic                          eq_o,
    output logic                          grp_prop_o,
    output logic                          grp_gen_o
);

    localparam int DW = SLICE_W * NUM_SLICES;

    logic [NUM_SLICES:0]   carry;
    logic [NUM_SLICES-1:0] slice_eq;
    grp_t                  slice_grp [NUM_SLICES];
    grp_t                  word_grp;

    assign carry[0] = cin_i;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        alu_slice #(.W(SLICE_W)) i_slice (
            .a_i    (a_i[s*SLICE_W +: SLICE_W]),
            .b_i    (b_i[s*SLICE_W +: SLICE_W]),
            .mode_i (mode_i),
            .sel_i  (sel_i),
            .cin_i  (carry[s]),
            .f_o    (f_o[s*SLICE_W +: SLICE_W]),
            .cout_o (carry[s+1]),
            .eq_o   (slice_eq[s]),
            .grp_o  (slice_grp[s])
        );
    end

    alu_carry_lookahead #(.N(NUM_SLICES)) i_cla (
        .grp_i  (slice_grp),
        .cin_i  (cin_i),
        .cout_o (cout_lookahead_o),
        .grp_o  (word_grp)
    );

    assign cout_ripple_o = carry[NUM_SLICES];
    assign eq_o          = &slice_eq;
    assign grp_prop_o    = word_grp.p;
    assign grp_gen_o     = word_grp.g;

    always_comb begin
        // R9
        cla_ripple_match_chk: assert (cout_lookahead_o == cout_ripple_o)
            else $error("lookahead and ripple carry differ");
        // R7
        word_eq_chk: assert (eq_o == (a_i == b_i))
            else $error("word equality mismatch");
        // R3
        logic_word_carry_chk: assert (!mode_i || (!cout_ripple_o && !grp_gen_o))
            else $error("logic mode word carry not zero");
    end

    logic [DW-1:0] unused_w;
    assign unused_w = '0;

endmodule

// File: tb/test_alu_cascade8.sv
module test_alu_cascade8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [7:0] a, b, f;
    logic       mode, cin, cr, cl, eq, gp, gg;
    logic [3:0] sel;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    alu_cascade8 i_alu_cascade8 (
        .a_i(a), .b_i(b), .mode_i(mode), .sel_i(sel), .cin_i(cin),
        .f_o(f), .cout_ripple_o(cr), .cout_lookahead_o(cl), .eq_o(eq),
        .grp_prop_o(gp), .grp_gen_o(gg)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h m=%0d s=%0d c=%0d)",
                     req, act, exp, a, b, mode, sel, cin);
        end
    endtask

    function automatic void ref_ops(input logic [7:0] ra, input logic [7:0] rb,
                                    input int s, output logic [7:0] x, output logic [7:0] y);
        case (s)
            0: begin x = ra; y = rb; end
            1: begin x = ra; y = ~rb; end
            2: begin x = ra; y = 8'h00; end
            3: begin x = ra; y = 8'hFF; end
            4: begin x = rb; y = ~ra; end
            5: begin x = ra; y = ra; end
            6: begin x = ra; y = ra & rb; end
            7: begin x = ra; y = ra | rb; end
            8: begin x = ra | rb; y = 8'h00; end
            9: begin x = ra & rb; y = 8'hFF; end
            10: begin x = ~ra; y = 8'h00; end
            11: begin x = rb; y = 8'h00; end
            12: begin x = rb; y = 8'hFF; end
            13: begin x = ra; y = ra & ~rb; end
            14: begin x = ra | ~rb; y = 8'h00; end
            default: begin x = ra ^ rb; y = 8'h00; end
        endcase
    endfunction

    function automatic logic [7:0] ref_logic(input logic [7:0] ra, input logic [7:0] rb, input int s);
        case (s)
            0: return ra & rb;
            1: return ra | rb;
            2: return ra ^ rb;
            3: return ~ra;
            4: return ~(ra & rb);
            5: return ~(ra | rb);
            6: return ~(ra ^ rb);
            7: return ra;
            8: return rb;
            9: return 8'h00;
            10: return 8'hFF;
            11: return ra & ~rb;
            12: return ~ra & rb;
            13: return ra | ~rb;
            14: return ~ra | rb;
            default: return ~rb;
        endcase
    endfunction

    task automatic apply(input logic [7:0] ta, input logic [7:0] tb, input bit tm,
                         input int ts, input bit tc);
        logic [7:0] x, y, ef;
        int total, egen;
        bit ecout, ep, eg;
        @(posedge clk);
        #1;
        a = ta; b = tb; mode = tm; sel = ts[3:0]; cin = tc;
        @(negedge clk);
        if (tm) begin
            ef = ref_logic(ta, tb, ts);
            ecout = 0; ep = 0; eg = 0;
            chk(f == ef, "R2", f, ef);
        end else begin
            ref_ops(ta, tb, ts, x, y);
            total = int'(x) + int'(y) + int'(tc);
            egen  = int'(x) + int'(y);
            ef = total[7:0];
            ecout = total > 255;
            ep = ((x ^ y) == 8'hFF);
            eg = egen > 255;
            chk(f == ef, "R4", f, ef);
        end
        chk(cr == ecout, tm ? "R3 ripple carry" : "R4 ripple carry", cr, ecout);
        chk(cl == cr, "R9 lookahead vs ripple", cl, cr);
        chk(eq == (ta == tb), "R7 equality", eq, ta == tb);
        chk(gp == ep, tm ? "R3 group propagate" : "R8 group propagate", gp, ep);
        chk(gg == eg, tm ? "R3 group generate" : "R8 group generate", gg, eg);
    endtask

    initial begin
        logic [7:0] pats [4];
        logic [7:0] f0, f1;
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hAA; pats[3] = 8'h55;
        a = 0; b = 0; mode = 0; sel = 0; cin = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // initial state: zero inputs, add code
        @(negedge clk);
        chk(f == 8'h00, "R5 zero add", f, 0);
        chk(eq == 1'b1, "R7 zero operands equal", eq, 1);

        // R1: same operands, both modes
        apply(8'h03, 8'h05, 0, 0, 0);
        chk(f == 8'h08, "R1 arithmetic add", f, 8'h08);
        apply(8'h03, 8'h05, 1, 0, 0);
        chk(f == 8'h01, "R1 logic AND", f, 8'h01);

        // R5 carry across slice boundary
        apply(8'h0F, 8'h01, 0, 0, 0);
        chk(f == 8'h10, "R5 nibble carry", f, 8'h10);
        apply(8'hFF, 8'h01, 0, 0, 0);
        chk(f == 8'h00 && cr == 1'b1, "R5 word wrap", {cr, f}, 9'h100);

        // R6 subtract example
        apply(8'h05, 8'h03, 0, 1, 1);
        chk(f == 8'h02 && cr == 1'b1, "R6 subtract 5-3", {cr, f}, 9'h102);

        // R10 OR example
        apply(8'h01, 8'h01, 1, 1, 0);
        chk(f == 8'h01, "R10 OR of ones", f, 8'h01);

        // R3: logic result unaffected by carry input
        for (int s = 0; s < 16; s++) begin
            apply(8'hC6, 8'h5A, 1, s, 0);
            f0 = f;
            apply(8'hC6, 8'h5A, 1, s, 1);
            f1 = f;
            chk(f0 == f1, "R3 cin ignored", f1, f0);
        end

        // exhaustive nibble pairs, every code, both modes and carries
        for (int al = 0; al < 16; al++)
            for (int bl = 0; bl < 16; bl++)
                for (int m = 0; m < 2; m++)
                    for (int s = 0; s < 16; s++)
                        for (int c = 0; c < 2; c++)
                            apply({al[3:0] ^ 4'h9, al[3:0]}, {bl[3:0], bl[3:0] ^ 4'h6},
                                  m[0], s, c[0]);

        // byte patterns crossed on both operands
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                for (int m = 0; m < 2; m++)
                    for (int s = 0; s < 16; s++)
                        for (int c = 0; c < 2; c++)
                            apply(pats[i], pats[j], m[0], s, c[0]);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule